// File: doc/BRIEF.md
# Configuration Control Sequencer

This block steps a programmable device through its configuration. A run starts when both supply-good flags are true after reset, or when the active-low program request falls at any later time. The block then drives DONE and INIT low and strobes the configuration memory clear for a fixed number of cycles. It waits while the program request is still held low, and then waits while some other agent holds the shared INIT line low. It latches the three mode pins, takes in a set number of frame words while folding them into a CRC-16, and compares the result with one final check word.

If the check word matches, the block drives DONE high, enables the user I/Os one cycle later, and releases the global set/reset one cycle after that. If the check word does not match, start-up is skipped. The block parks in an error state with INIT pulled low until a new program request arrives.

INIT is an open-drain line. The block only asserts a pull-low enable and reads the wired level back on `init_in`. Every input except `prog_n` is taken as synchronous to `clk`. `prog_n` passes through a two-flop synchroniser.

Top module: `cfg_seq`

## Requirements
- R1: After reset the block stays idle until `core_pwr_ok` and `io_pwr_ok` are both 1. While idle, `init_drive_low`=1, `done_out`=0 and `mem_clr`=0.
- R2: Each configuration run asserts `mem_clr` for exactly CLR_CYCLES (default 64) consecutive cycles. During those cycles `done_out`=0 and `init_drive_low`=1.
- R3: After the clear, while the synchronised `prog_n` is still 0, the block keeps `init_drive_low`=1 and `mem_clr`=0. It does not proceed.
- R4: Once the program request is released, the block stops driving INIT (`init_drive_low`=0). It waits as long as the wired `init_in` reads 0.
- R5: On the clock edge where `init_in` is first seen as 1 in that wait, `mode_pins` are latched into `cfg_mode`. `cfg_mode` ignores later pin changes until the next run latches it again.
- R6: In the load phase, each cycle with `frm_valid`=1 takes one 32-bit word, and cycles with `frm_valid`=0 are ignored. The word is folded MSB first into a CRC-16 with polynomial 0x8005 and initial value 0. After FRAMES (default 16) words, the next valid word carries the expected CRC in bits 15:0.
- R7: On a CRC match, `done_out` rises in the next cycle. `io_en` rises one cycle later and `gsr_release` one cycle after that. All three then stay high.
- R8: On a CRC mismatch, `crc_err`=1, `init_drive_low`=1 and `done_out`=`io_en`=`gsr_release`=0. This holds, whatever frames arrive, until a program request.
- R9: In any state except the power wait, a fall of `prog_n` restarts at the clear. `done_out`, `io_en`, `gsr_release` and `crc_err` go to 0, and `mem_clr` goes to 1, in the third cycle after the fall is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_pwr_ok | input | 1 | Core supply good |
| io_pwr_ok | input | 1 | Configuration I/O bank supply good |
| prog_n | input | 1 | Asynchronous active-low program request |
| init_in | input | 1 | Wired level of the open-drain INIT line |
| mode_pins | input | 3 | Configuration mode pins |
| frm_data | input | 32 | Frame word / check word |
| frm_valid | input | 1 | Frame word strobe |
| done_out | output | 1 | DONE drive (1 = configured) |
| init_drive_low | output | 1 | Pull-low enable for INIT |
| mem_clr | output | 1 | Configuration memory clear strobe |
| io_en | output | 1 | User I/O enable |
| gsr_release | output | 1 | Global set/reset released |
| crc_err | output | 1 | CRC mismatch error |
| cfg_mode | output | 3 | Latched mode pins |

## Verification
All outputs decode the state register directly, so a change on a synchronous input shows up in the cycle after the edge that samples it. A change on `prog_n` shows up two edges later, after the synchroniser and the edge detector. The bench drives inputs on falling edges and samples on the next falling edge. For a program fall it samples on the second and third falling edges, expecting the old outputs and then the restarted ones. The clear-strobe length is counted edge by edge. The start-up order is checked on three successive falling edges after the check word. Each hold is shown by a mode-pin value that changes only when the hold is lifted.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  localparam int WORD_W = 32;
  localparam int CRC_W  = 16;
  localparam int MODE_W = 3;

  typedef enum logic [3:0] {
    ST_PWR,
    ST_CLR,
    ST_PROG_HOLD,
    ST_INIT_HOLD,
    ST_LOAD,
    ST_CHECK,
    ST_SU_DONE,
    ST_SU_IO,
    ST_USER,
    ST_FAIL
  } cfg_state_e;

  // Serial CRC step, one word, most significant bit first.
  function automatic logic [CRC_W-1:0] crc_word(
    input logic [CRC_W-1:0]  cur,
    input logic [WORD_W-1:0] data,
    input logic [CRC_W-1:0]  poly
  );
    logic [CRC_W-1:0] c;
    logic             fb;
    c = cur;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ data[i];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    end
    return c;
  endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cfg_crc.sv
module cfg_crc
  import cfg_seq_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 16'h8005
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd,
  input  logic [WORD_W-1:0] data,
  output logic [CRC_W-1:0]  crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= '0;
    else if (clr) crc <= '0;
    else if (upd) crc <= crc_word(crc, data, POLY);
  end

  AST_CRC_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !upd) |=> $stable(crc)); // R6
  AST_CRC_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc == '0)); // R6
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfg_seq_pkg::*;
#(
  parameter int               FRAMES     = 16,
  parameter int               CLR_CYCLES = 64,
  parameter logic [CRC_W-1:0] CRC_POLY   = 16'h8005
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_pwr_ok,
  input  logic              io_pwr_ok,
  input  logic              prog_n,
  input  logic              init_in,
  input  logic [MODE_W-1:0] mode_pins,
  input  logic [WORD_W-1:0] frm_data,
  input  logic              frm_valid,
  output logic              done_out,
  output logic              init_drive_low,
  output logic              mem_clr,
  output logic              io_en,
  output logic              gsr_release,
  output logic              crc_err,
  output logic [MODE_W-1:0] cfg_mode
);
  localparam int CNT_MAX = (CLR_CYCLES > FRAMES) ? CLR_CYCLES : FRAMES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] CLR_LAST = CNT_W'(CLR_CYCLES - 1);
  localparam logic [CNT_W-1:0] FRM_LAST = CNT_W'(FRAMES - 1);

  cfg_state_e       st, nxt;
  logic [CNT_W-1:0] cnt;
  logic             prog_s, prog_prev;
  logic [CRC_W-1:0] crc_val;

  // Named internal events
  logic prog_fall, restart, pwr_good, clear_last, load_word, load_last;
  logic check_word, crc_match, mode_take, crc_clr;

  cfg_sync #(.STAGES(2), .RST_VAL(1'b1)) u_prog_sync (
    .clk(clk), .rst_n(rst_n), .d(prog_n), .q(prog_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prog_prev <= 1'b1;
    else        prog_prev <= prog_s;
  end

  assign prog_fall  = prog_prev & ~prog_s;
  assign restart    = prog_fall && (st != ST_PWR);
  assign pwr_good   = core_pwr_ok && io_pwr_ok;
  assign clear_last = (st == ST_CLR) && (cnt == CLR_LAST);
  assign load_word  = (st == ST_LOAD) && frm_valid;
  assign load_last  = load_word && (cnt == FRM_LAST);
  assign check_word = (st == ST_CHECK) && frm_valid;
  assign crc_match  = (frm_data[CRC_W-1:0] == crc_val);
  assign mode_take  = (st == ST_INIT_HOLD) && init_in && !restart;
  assign crc_clr    = (st != ST_LOAD) && (st != ST_CHECK);

  always_comb begin
    nxt = st;
    unique case (st)
      ST_PWR:       if (pwr_good)   nxt = ST_CLR;
      ST_CLR:       if (clear_last) nxt = ST_PROG_HOLD;
      ST_PROG_HOLD: if (prog_s)     nxt = ST_INIT_HOLD;
      ST_INIT_HOLD: if (init_in)    nxt = ST_LOAD;
      ST_LOAD:      if (load_last)  nxt = ST_CHECK;
      ST_CHECK:     if (check_word) nxt = crc_match ? ST_SU_DONE : ST_FAIL;
      ST_SU_DONE:                   nxt = ST_SU_IO;
      ST_SU_IO:                     nxt = ST_USER;
      ST_USER:                      nxt = ST_USER;
      ST_FAIL:                      nxt = ST_FAIL;
      default:                      nxt = ST_PWR;
    endcase
    if (restart) nxt = ST_CLR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_PWR;
    else        st <= nxt;
  end

  // One counter serves the clear length and the frame count.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 cnt <= '0;
    else if (restart || (st != nxt))            cnt <= '0;
    else if ((st == ST_CLR) || load_word)       cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cfg_mode <= '0;
    else if (mode_take) cfg_mode <= mode_pins;
  end

  cfg_crc #(.POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .upd(load_word),
    .data(frm_data), .crc(crc_val)
  );

  assign done_out       = (st == ST_SU_DONE) || (st == ST_SU_IO) || (st == ST_USER);
  assign io_en          = (st == ST_SU_IO) || (st == ST_USER);
  assign gsr_release    = (st == ST_USER);
  assign mem_clr        = (st == ST_CLR);
  assign crc_err        = (st == ST_FAIL);
  assign init_drive_low = (st == ST_PWR) || (st == ST_CLR) ||
                          (st == ST_PROG_HOLD) || (st == ST_FAIL);

  AST_PWR_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PWR && !pwr_good) |=> (st == ST_PWR)); // R1
  AST_CLR_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CLR && !clear_last && !restart) |=> mem_clr); // R2
  AST_CLR_OUTS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_clr |-> (init_drive_low && !done_out)); // R2
  AST_PROG_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PROG_HOLD && !prog_s) |=> (st == ST_PROG_HOLD)); // R3
  AST_INIT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_INIT_HOLD && !init_in && !restart) |=> (st == ST_INIT_HOLD)); // R4
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_LOAD || st == ST_CHECK) &&
     ($past(st) == ST_LOAD || $past(st) == ST_CHECK)) |-> $stable(cfg_mode)); // R5
  AST_IO_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_en) |-> $past(done_out)); // R7
  AST_GSR_AFTER_IO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gsr_release) |-> $past(io_en)); // R7
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err && !restart) |=> (crc_err && init_drive_low && !done_out)); // R8
  AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (mem_clr && !done_out && !crc_err)); // R9
endmodule

// File: tb/cfg_seq_tb.sv
module cfg_seq_tb;
  localparam int FRAMES = 16;
  localparam int CLR_N  = 64;

  logic        clk = 1'b0;
  logic        rst_n, core_ok, io_ok, prog_n, ext_hold, frm_valid;
  logic [2:0]  mode_pins;
  logic [31:0] frm_data;
  wire         done_out, init_drive_low, mem_clr, io_en, gsr_release, crc_err;
  wire [2:0]   cfg_mode;
  wire         init_line = !(init_drive_low || ext_hold);

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cfg_seq #(.FRAMES(FRAMES), .CLR_CYCLES(CLR_N)) u_dut (
    .clk(clk), .rst_n(rst_n), .core_pwr_ok(core_ok), .io_pwr_ok(io_ok),
    .prog_n(prog_n), .init_in(init_line), .mode_pins(mode_pins),
    .frm_data(frm_data), .frm_valid(frm_valid), .done_out(done_out),
    .init_drive_low(init_drive_low), .mem_clr(mem_clr), .io_en(io_en),
    .gsr_release(gsr_release), .crc_err(crc_err), .cfg_mode(cfg_mode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Remainder of (r*x^32 + d*x^16) modulo the generator, by long division.
  function automatic logic [15:0] ref_crc(input logic [15:0] r, input logic [31:0] d);
    logic [47:0] v;
    v = {r, 32'h0} ^ {d, 16'h0};
    for (int i = 47; i >= 16; i--)
      if (v[i]) v = v ^ (48'h18005 << (i - 16));
    return v[15:0];
  endfunction

  task automatic count_clear(input string tag);
    int n = 0;
    while (mem_clr && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk({tag, " R2 clear length"}, n, CLR_N);
  endtask

  // Entered at a negedge inside the load phase; leaves at the negedge after the check word.
  task automatic send_load(input logic [31:0] seed, input bit corrupt);
    logic [15:0] c = 16'h0;
    logic [31:0] w;
    for (int i = 0; i < FRAMES; i++) begin
      if (i % 5 == 2) begin
        frm_valid = 1'b0;
        frm_data  = 32'hDEAD_0000 | i;
        @(negedge clk);
      end
      w = (seed * (i + 3)) ^ {i[7:0], 24'h5A3C19};
      frm_valid = 1'b1;
      frm_data  = w;
      c = ref_crc(c, w);
      @(negedge clk);
    end
    frm_valid = 1'b0;
    frm_data  = 32'hFFFF_FFFF;
    @(negedge clk);
    frm_valid = 1'b1;
    frm_data  = {16'hA5A5, corrupt ? (c ^ 16'h0100) : c};
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic wait_load_entry;
    int n = 0;
    while (!(init_drive_low == 1'b0 && !ext_hold) && n < 2000) begin
      n++;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic check_startup(input string tag);
    chk({tag, " R7 done"}, done_out, 1);
    chk({tag, " R7 io not yet"}, io_en, 0);
    chk({tag, " R7 gsr not yet"}, gsr_release, 0);
    @(negedge clk);
    chk({tag, " R7 io"}, {done_out, io_en, gsr_release}, 3'b110);
    @(negedge clk);
    chk({tag, " R7 gsr"}, {done_out, io_en, gsr_release}, 3'b111);
    chk({tag, " R6 no error"}, crc_err, 0);
  endtask

  task automatic t_reset;
    rst_n = 0; core_ok = 0; io_ok = 0; prog_n = 1; ext_hold = 0;
    frm_valid = 0; frm_data = '0; mode_pins = 3'b101;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {done_out, init_drive_low, mem_clr, io_en, gsr_release, crc_err},
        6'b010000);
    rst_n = 1;
  endtask

  task automatic t_cold_boot;
    core_ok = 1;
    repeat (20) @(negedge clk);
    chk("R1 one supply only", {mem_clr, init_drive_low, done_out}, 3'b010);
    io_ok = 1;
    @(negedge clk);
    chk("R2 clear starts", {mem_clr, init_drive_low, done_out}, 3'b110);
    count_clear("boot");
    chk("R3 pass-through hold drives INIT", init_drive_low, 1);
    @(negedge clk);
    chk("R4 INIT released", init_drive_low, 0);
    @(negedge clk);
    chk("R5 mode latched", cfg_mode, 3'b101);
    mode_pins = 3'b010;
    send_load(32'h1357_9BDF, 1'b0);
    check_startup("boot");
    chk("R5 mode held", cfg_mode, 3'b101);
    frm_valid = 1; frm_data = 32'h0;
    repeat (3) @(negedge clk);
    frm_valid = 0;
    chk("R6 words ignored in user", {done_out, io_en, gsr_release, crc_err}, 4'b1110);
  endtask

  task automatic t_holds_and_bad_crc;
    prog_n = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R9 not yet restarted", done_out, 1);
    @(negedge clk);
    chk("R9 restart", {done_out, io_en, gsr_release, mem_clr}, 4'b0001);
    repeat (100) @(negedge clk);
    chk("R3 waits on program", {mem_clr, init_drive_low, done_out}, 3'b010);
    ext_hold = 1; mode_pins = 3'b110;
    prog_n = 1;
    repeat (12) @(negedge clk);
    chk("R4 waits on INIT", {init_drive_low, init_line, done_out}, 3'b000);
    ext_hold = 0; mode_pins = 3'b011;
    @(negedge clk);
    @(negedge clk);
    chk("R5 R4 mode after hold", cfg_mode, 3'b011);
    send_load(32'h2468_ACE0, 1'b1);
    chk("R8 error", {crc_err, init_drive_low, done_out, io_en, gsr_release}, 5'b11000);
    frm_valid = 1; frm_data = 32'h1234_5678;
    repeat (8) @(negedge clk);
    frm_valid = 0;
    chk("R8 error sticky", {crc_err, init_drive_low, done_out, io_en}, 4'b1100);
  endtask

  task automatic t_recover;
    prog_n = 0;
    repeat (3) @(negedge clk);
    chk("R9 error cleared", {crc_err, mem_clr}, 2'b01);
    prog_n = 1;
    count_clear("recover");
    mode_pins = 3'b111;
    wait_load_entry();
    chk("R5 mode relatched", cfg_mode, 3'b111);
    send_load(32'h0F0F_1234, 1'b0);
    check_startup("recover");
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_cold_boot();
    t_holds_and_bad_crc();
    t_recover();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule